// File: doc/BRIEF.md
# Two-Master Bus Arbiter with Tenure Timeout

This block decides which of two masters may drive a shared peripheral bus. One master is the processor (`cpu_*` pins) and the other is a DMA engine (`dma_*` pins). Each master raises a request and waits for its grant. A master that holds a grant keeps it while it keeps either its request or its lock pin high. It gives the bus back by lowering both. When both masters ask while the bus is free, the DMA engine wins.

To keep a long burst from starving the other master, a tenure counter is reloaded on every new grant and counts each owned cycle. After `MAX_CYC` cycles of ownership the grant is taken away, even if the lock is still held. If the other master is waiting, it gets the bus on that same edge. The forced removal is flagged by a one-cycle `tenure_tmo` pulse. All outputs come from registers. Control pins are plain levels, and there is no data path, so no valid/ready handshake is involved.

Top module: `arb2_timeout`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cpu_gnt`, `dma_gnt` and `tenure_tmo` are all 0.
- R2: At most one of `cpu_gnt` and `dma_gnt` is 1 in any cycle.
- R3: A grant is only given to a master whose request is 1 at the deciding edge. A lock pin that is high without the request never wins the bus.
- R4: When the bus is free and `dma_req` is 1 at an edge, `dma_gnt` is 1 after that edge, whether or not `cpu_req` is also 1.
- R5: An owner keeps its grant while its request or its lock is 1, as long as its tenure has not run out. Lock alone is enough to keep a grant once held.
- R6: When the owner lowers both its request and its lock, its grant falls at the next edge. If the other master is requesting at that edge, the other grant rises on the same edge, with no idle cycle between.
- R7: A grant stays high for at most `MAX_CYC` consecutive cycles (default 32). If the owner still holds request or lock, the grant falls after the `MAX_CYC`-th cycle.
- R8: On a forced removal, the other master gets the grant on the same edge if it is requesting. If it is not, the bus stays free for one cycle and is then arbitrated normally.
- R9: `tenure_tmo` is 1 for exactly one cycle: the first cycle after a forced removal. It is 0 after voluntary releases. When the owner releases in the same cycle that its tenure runs out, the removal counts as forced.
- R10: Every new grant, including a direct handover, starts a full tenure of `MAX_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor asks for the bus |
| cpu_lock | input | 1 | Processor holds the bus across a burst |
| dma_req | input | 1 | DMA engine asks for the bus |
| dma_lock | input | 1 | DMA engine holds the bus across a burst |
| cpu_gnt | output | 1 | Processor owns the bus |
| dma_gnt | output | 1 | DMA engine owns the bus |
| tenure_tmo | output | 1 | One-cycle pulse after a tenure was cut short |

## Verification
A voluntary release and a tenure expiry can fall on the same edge. The bench provokes this by having the DMA engine drop its request exactly in its 32nd owned cycle while the processor is waiting. The result is judged by requiring the timeout pulse together with a direct handover to the processor, which then runs a full fresh tenure. A second collision, expiry against a waiting requester whose request is still held, is judged by the handover edge and by the grant returning to the DMA engine once the processor's own tenure ends.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_CPU  = 2'd1,
    OWN_DMA  = 2'd2
  } owner_e;
endpackage

// File: rtl/arb2_pick.sv
module arb2_pick
  import arb2_pkg::*;
(
  input  logic   cpu_req,
  input  logic   dma_req,
  output owner_e winner
);
  // fixed priority: DMA engine first
  always_comb begin
    if (dma_req)      winner = OWN_DMA;
    else if (cpu_req) winner = OWN_CPU;
    else              winner = OWN_NONE;
  end
endmodule

// File: rtl/arb2_tenure_timer.sv
module arb2_tenure_timer #(
  parameter int MAX_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(MAX_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (load)               cnt_q <= LOAD_VAL;
    else if (run && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = run && (cnt_q == '0);

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == LOAD_VAL));
endmodule

// File: rtl/arb2_timeout.sv
module arb2_timeout
  import arb2_pkg::*;
#(
  parameter int MAX_CYC = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_req,
  input  logic cpu_lock,
  input  logic dma_req,
  input  logic dma_lock,
  output logic cpu_gnt,
  output logic dma_gnt,
  output logic tenure_tmo
);
  owner_e owner_q, owner_d, winner;
  logic   tmo_q, tmo_d;
  logic   hold, other_req, tenure_end, load, run;
  owner_e other;

  arb2_pick u_pick (
    .cpu_req (cpu_req),
    .dma_req (dma_req),
    .winner  (winner)
  );

  arb2_tenure_timer #(.MAX_CYC(MAX_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .run     (run),
    .expired (tenure_end)
  );

  always_comb begin
    hold      = 1'b0;
    other_req = 1'b0;
    other     = OWN_NONE;
    case (owner_q)
      OWN_CPU: begin
        hold = cpu_req | cpu_lock; other_req = dma_req; other = OWN_DMA;
      end
      OWN_DMA: begin
        hold = dma_req | dma_lock; other_req = cpu_req; other = OWN_CPU;
      end
      default: ;
    endcase
  end

  always_comb begin
    owner_d = owner_q;
    tmo_d   = 1'b0;
    if (owner_q == OWN_NONE) begin
      owner_d = winner;
    end else if (tenure_end) begin
      tmo_d   = 1'b1;
      owner_d = other_req ? other : OWN_NONE;
    end else if (!hold) begin
      owner_d = winner;
    end
  end

  assign run  = (owner_q != OWN_NONE);
  assign load = (owner_d != OWN_NONE) && (owner_d != owner_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= OWN_NONE;
      tmo_q   <= 1'b0;
    end else begin
      owner_q <= owner_d;
      tmo_q   <= tmo_d;
    end
  end

  assign cpu_gnt    = (owner_q == OWN_CPU);
  assign dma_gnt    = (owner_q == OWN_DMA);
  assign tenure_tmo = tmo_q;

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, dma_gnt}));
  // R3
  cpu_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |=> !$rose(cpu_gnt));
  // R3
  dma_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req |=> !$rose(dma_gnt));
  // R4
  dma_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_gnt && !dma_gnt && dma_req) |=> dma_gnt);
  // R5
  cpu_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && (cpu_req || cpu_lock) && !tenure_end) |=> cpu_gnt);
  // R5
  dma_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_gnt && (dma_req || dma_lock) && !tenure_end) |=> dma_gnt);
  // R9
  tmo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_tmo |=> !tenure_tmo);
  // R9
  tmo_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tenure_tmo |-> ($fell(cpu_gnt) || $fell(dma_gnt)));
endmodule

// File: tb/arb2_timeout_tb.sv
module arb2_timeout_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req = 0, cpu_lock = 0, dma_req = 0, dma_lock = 0;
  logic cpu_gnt, dma_gnt, tenure_tmo;
  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic c; logic d; logic t; string tag; } exp_t;
  exp_t sb_q[$];

  always #10 clk = ~clk; // 50 MHz

  arb2_timeout dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_lock(cpu_lock),
    .dma_req(dma_req), .dma_lock(dma_lock),
    .cpu_gnt(cpu_gnt), .dma_gnt(dma_gnt), .tenure_tmo(tenure_tmo)
  );

  task automatic chk(input logic c, d, t, input string tag);
    total++;
    if ({cpu_gnt, dma_gnt, tenure_tmo} !== {c, d, t}) begin
      bad++;
      $display("FAIL %s: got cpu/dma/tmo=%b%b%b exp=%b%b%b",
               tag, cpu_gnt, dma_gnt, tenure_tmo, c, d, t);
    end
  endtask

  // driver: set inputs at negedge, push expected outputs after next edge
  task automatic step(input logic cr, cl, dr, dl, ec, ed, et, input string tag);
    @(negedge clk);
    cpu_req = cr; cpu_lock = cl; dma_req = dr; dma_lock = dl;
    sb_q.push_back('{c: ec, d: ed, t: et, tag: tag});
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(e.c, e.d, e.t, e.tag);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(0, 0, 0, "R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(0, 0, 0, "R1 after reset");

    // CPU alone
    step(1,0,0,0, 1,0,0, "R3 cpu grant");
    for (int i = 0; i < 3; i++) step(1,0,0,0, 1,0,0, "R5 cpu hold");
    step(0,0,0,0, 0,0,0, "R6 cpu release");

    // both request at idle, then handover
    step(1,0,1,0, 0,1,0, "R4 dma first");
    step(1,0,1,0, 0,1,0, "R5 dma hold");
    step(1,0,0,0, 1,0,0, "R6 handover");
    step(0,0,0,0, 0,0,0, "R6 release");

    // lock without request, then lock keeps grant
    step(0,1,0,0, 0,0,0, "R3 lock alone");
    step(0,1,0,1, 0,0,0, "R3 locks alone");
    step(1,1,0,0, 1,0,0, "R3 cpu req+lock");
    for (int i = 0; i < 3; i++) step(0,1,1,0, 1,0,0, "R5 lock keeps");
    step(0,0,1,0, 0,1,0, "R6 lock drop handover");
    step(0,0,0,0, 0,0,0, "R6 dma release");

    // DMA tenure expiry coinciding with release, CPU waiting
    for (int k = 1; k <= 32; k++)
      step((k >= 5), 0, 1, 0, 0, 1, 0, "R7 dma tenure");
    step(1,0,0,0, 1,0,1, "R9 expiry wins over release");
    for (int k = 34; k <= 64; k++)
      step(1, 0, (k >= 40), 0, 1, 0, 0, "R10 cpu full tenure");
    step(1,0,1,0, 0,1,1, "R8 expiry hands to dma");
    step(0,0,1,0, 0,1,0, "R9 pulse one cycle");
    step(0,0,0,0, 0,0,0, "R6 release");

    // expiry with nobody waiting, lock held
    step(0,0,1,1, 0,1,0, "R4 dma grant");
    for (int k = 2; k <= 32; k++) step(0,0,0,1, 0,1,0, "R7 lock tenure");
    step(0,0,1,1, 0,0,1, "R8 idle after expiry");
    step(0,0,1,1, 0,1,0, "R8 re-arbitrate");
    step(0,0,0,0, 0,0,0, "R6 release");
    @(negedge clk); @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: got hung exp=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule